// File: doc/BRIEF.md
# Masked Vector Gather Sequencer

This block runs a masked gather into a vector register. Software hands it a scalar base address, one index per element, a per-element enable mask and the current destination contents, then pulses `start`. The block forms every element address as base plus index, splits the gather into single-element loads and sends them through a small set of load ports to a request/response memory interface. Each returned element is written into its slot of the destination, and the element's mask bit is cleared at the same edge. Elements that are disabled at start are never fetched and keep their old value.

Loads are issued by 128-bit lane group. The lowest group that still holds unissued enabled elements is served first, and inside it elements leave in ascending order. When several ports can take a request in the same cycle, the lowest pending element goes to port 0. An `abort` input stops further issue. Loads already in flight are drained and merged, then the block parks with `suspended` high. `mask_out` and `dst_out` then hold the partial state. Feeding those two values back with a new `start` fetches only what is left. A build parameter selects parallel writeback, where every port may merge in the same cycle, or serialized writeback, where at most one element is merged per cycle.

Each request port is valid/ready. A request counts as issued only in a cycle with both `req_valid` and `req_ready` high. A request that is not accepted may be withdrawn when `abort` rises, or offered again on a lower port in a later cycle. Each response port is valid/ready too. The memory side must hold `resp_valid`, `resp_data` and `resp_tag` until `resp_ready` is high. In parallel mode `resp_ready` is always high. The tag on a response must be the tag of the request it answers.

Top module: `gather_seq`

## Requirements
- R1: The address of element i is the base plus index i, computed modulo 2^ADDR_W. Any byte address is allowed, including odd ones.
- R2: `base_in` and `idx_in` are captured only at the `start` edge. Changing them while the block is busy has no effect on the addresses it issues.
- R3: An element whose `mask_in` bit is 0 is never requested, and its `dst_out` slot keeps the `dst_in` value. Every enabled element is requested exactly once, and its slot receives the returned data.
- R4: Requests are accepted in strictly ascending element order. When ports 0 and 1 are valid in the same cycle, port 0 carries the lower element. Elements 0..3 form lane group 0 and elements 4..7 form lane group 1, and group 0 is served first.
- R5: In parallel mode, with every port always ready and a memory that answers one cycle after acceptance, a full 8-element gather raises `done` 7 clock edges after the edge that samples `start`. An all-zero mask raises `done` 2 edges after that edge.
- R6: In serialized mode at most one response handshake completes per cycle. A gather of k > 0 elements therefore raises `done` no sooner than k+3 edges after the `start` edge.
- R7: While `abort` is high, no request is valid. The block finishes the loads in flight and then returns to idle with `suspended` high. At that point `mask_out` holds exactly the enabled elements that were never issued, and `dst_out` holds the merged data.
- R8: A new `start` with the suspended `mask_out` and `dst_out` fetches only the remaining elements and produces the same final destination as a gather that was never interrupted.
- R9: `done` is high for exactly one cycle per completed gather. While it is high, `mask_out` is all zeros and `busy` is low.
- R10: After reset, `busy`, `done` and `suspended` are low, `mask_out` is zero, and no request is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a gather. Taken only when idle. |
| abort | input | 1 | Stop issuing new loads and suspend |
| base_in | input | ADDR_W | Scalar base address |
| idx_in | input | NUM_ELEM*IDX_W | Per-element indices, element 0 in the low bits |
| mask_in | input | NUM_ELEM | Per-element enables |
| dst_in | input | NUM_ELEM*ELEM_W | Prior destination contents |
| req_valid | output | NUM_PORTS | Load request valid, one bit per port |
| req_ready | input | NUM_PORTS | Load request ready, one bit per port |
| req_addr | output | NUM_PORTS*ADDR_W | Byte address of each request |
| req_tag | output | NUM_PORTS*TAG_W | Element number of each request |
| resp_valid | input | NUM_PORTS | Load response valid |
| resp_ready | output | NUM_PORTS | Load response ready |
| resp_data | input | NUM_PORTS*ELEM_W | Loaded element data |
| resp_tag | input | NUM_PORTS*TAG_W | Element number of each response |
| dst_out | output | NUM_ELEM*ELEM_W | Destination register contents |
| mask_out | output | NUM_ELEM | Mask of elements still outstanding |
| busy | output | 1 | Gather in progress |
| done | output | 1 | One-cycle pulse when a gather completes |
| suspended | output | 1 | Gather parked after an abort |

## Verification
Counting from the edge that samples `start`, the setup cycle ends at edge 1. Requests are accepted from edge 2. The bench memory answers one edge after acceptance, and each merge lands one edge later still. This puts `done` at edge 7 for a full parallel gather, at edge 2 for an empty mask, and at edge k+3 or later for k serialized elements. The bench drives inputs 2 ns after a rising edge and samples every output on the falling edge. It counts rising edges from the start edge and compares that count with these figures. Accepted requests are logged at the falling edge before the edge that takes them, so address, order and mask checks apply to the exact handshake cycle. For an abort raised before edge 3, the bench expects the suspended state to show exactly the elements taken at edge 2.

// File: rtl/gather_pkg.sv
package gather_pkg;
  typedef enum logic [1:0] {
    GS_IDLE  = 2'd0,
    GS_SETUP = 2'd1,
    GS_ISSUE = 2'd2,
    GS_DRAIN = 2'd3
  } gs_state_e;
endpackage

// File: rtl/gather_pick.sv
// Picks up to NUM_PORTS pending elements from the lowest lane group
// that still has work, in ascending element order.
module gather_pick #(
  parameter int NUM_ELEM   = 8,
  parameter int NUM_PORTS  = 2,
  parameter int LANE_ELEMS = 4,
  parameter int TAG_W      = 3
) (
  input  logic [NUM_ELEM-1:0]        pending,
  output logic [NUM_PORTS-1:0]       sel_valid,
  output logic [NUM_PORTS*TAG_W-1:0] sel_tag
);
  localparam int NUM_GROUPS = NUM_ELEM / LANE_ELEMS;

  int grp;
  int cnt;

  always_comb begin
    grp = 0;
    for (int g = NUM_GROUPS - 1; g >= 0; g--) begin
      if (|pending[g*LANE_ELEMS +: LANE_ELEMS]) grp = g;
    end
    cnt       = 0;
    sel_valid = '0;
    sel_tag   = '0;
    for (int e = 0; e < NUM_ELEM; e++) begin
      if ((e / LANE_ELEMS) == grp && pending[e] && cnt < NUM_PORTS) begin
        sel_valid[cnt]             = 1'b1;
        sel_tag[cnt*TAG_W +: TAG_W] = TAG_W'(e);
        cnt++;
      end
    end
  end
endmodule

// File: rtl/gather_merge.sv
// Destination and mask registers: loaded at start, updated per writeback.
module gather_merge #(
  parameter int NUM_ELEM  = 8,
  parameter int NUM_PORTS = 2,
  parameter int ELEM_W    = 32,
  parameter int TAG_W     = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic [NUM_ELEM*ELEM_W-1:0]  load_dst,
  input  logic [NUM_ELEM-1:0]         load_mask,
  input  logic [NUM_PORTS-1:0]        wb_valid,
  input  logic [NUM_PORTS*TAG_W-1:0]  wb_tag,
  input  logic [NUM_PORTS*ELEM_W-1:0] wb_data,
  output logic [NUM_ELEM*ELEM_W-1:0]  dst_q,
  output logic [NUM_ELEM-1:0]         mask_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dst_q  <= '0;
      mask_q <= '0;
    end else if (load) begin
      dst_q  <= load_dst;
      mask_q <= load_mask;
    end else begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (wb_valid[p]) begin
          dst_q[wb_tag[p*TAG_W +: TAG_W]*ELEM_W +: ELEM_W] <= wb_data[p*ELEM_W +: ELEM_W];
          mask_q[wb_tag[p*TAG_W +: TAG_W]]                  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/gather_seq.sv
module gather_seq
  import gather_pkg::*;
#(
  parameter int NUM_ELEM  = 8,
  parameter int ELEM_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 32,
  parameter int NUM_PORTS = 2,
  parameter int LANE_W    = 128,
  parameter bit SERIAL_WB = 1'b0,
  localparam int TAG_W    = $clog2(NUM_ELEM)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          abort,
  input  logic [ADDR_W-1:0]             base_in,
  input  logic [NUM_ELEM*IDX_W-1:0]     idx_in,
  input  logic [NUM_ELEM-1:0]           mask_in,
  input  logic [NUM_ELEM*ELEM_W-1:0]    dst_in,
  output logic [NUM_PORTS-1:0]          req_valid,
  input  logic [NUM_PORTS-1:0]          req_ready,
  output logic [NUM_PORTS*ADDR_W-1:0]   req_addr,
  output logic [NUM_PORTS*TAG_W-1:0]    req_tag,
  input  logic [NUM_PORTS-1:0]          resp_valid,
  output logic [NUM_PORTS-1:0]          resp_ready,
  input  logic [NUM_PORTS*ELEM_W-1:0]   resp_data,
  input  logic [NUM_PORTS*TAG_W-1:0]    resp_tag,
  output logic [NUM_ELEM*ELEM_W-1:0]    dst_out,
  output logic [NUM_ELEM-1:0]           mask_out,
  output logic                          busy,
  output logic                          done,
  output logic                          suspended
);
  localparam int LANE_ELEMS = LANE_W / ELEM_W;
  localparam int CNT_W      = $clog2(NUM_ELEM + 1) + 1;

  gs_state_e                    state;
  logic [ADDR_W-1:0]            base_r;
  logic [NUM_ELEM*IDX_W-1:0]    idx_r;
  logic [NUM_ELEM*ADDR_W-1:0]   addr_r;
  logic [NUM_ELEM-1:0]          issued_r;
  logic [CNT_W-1:0]             outst_r;
  logic                         done_r;
  logic                         susp_r;

  logic [NUM_ELEM-1:0]          pending;
  logic [NUM_PORTS-1:0]         sel_valid;
  logic [NUM_PORTS*TAG_W-1:0]   sel_tag;
  logic [NUM_PORTS-1:0]         accepted;
  logic [NUM_PORTS-1:0]         wb_valid;
  logic [CNT_W-1:0]             n_acc;
  logic [CNT_W-1:0]             n_wb;
  logic                         load;

  assign pending = mask_out & ~issued_r;
  assign load    = (state == GS_IDLE) && start;

  gather_pick #(
    .NUM_ELEM  (NUM_ELEM),
    .NUM_PORTS (NUM_PORTS),
    .LANE_ELEMS(LANE_ELEMS),
    .TAG_W     (TAG_W)
  ) u_pick (
    .pending  (pending),
    .sel_valid(sel_valid),
    .sel_tag  (sel_tag)
  );

  // Request side: addresses come from the setup-cycle address table
  assign req_valid = (state == GS_ISSUE && !abort) ? sel_valid : '0;
  assign req_tag   = sel_tag;

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_req
      assign req_addr[p*ADDR_W +: ADDR_W] = addr_r[sel_tag[p*TAG_W +: TAG_W]*ADDR_W +: ADDR_W];
    end
  endgenerate

  assign accepted = req_valid & req_ready;

  // Response side: writeback width chosen by parameter
  generate
    if (SERIAL_WB) begin : g_wb_serial
      assign resp_ready[0] = 1'b1;
      for (genvar p = 1; p < NUM_PORTS; p++) begin : g_rr
        assign resp_ready[p] = ~|resp_valid[p-1:0];
      end
    end else begin : g_wb_parallel
      assign resp_ready = '1;
    end
  endgenerate

  assign wb_valid = resp_valid & resp_ready;
  assign n_acc    = CNT_W'($countones(accepted));
  assign n_wb     = CNT_W'($countones(wb_valid));

  gather_merge #(
    .NUM_ELEM (NUM_ELEM),
    .NUM_PORTS(NUM_PORTS),
    .ELEM_W   (ELEM_W),
    .TAG_W    (TAG_W)
  ) u_merge (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_dst (dst_in),
    .load_mask(mask_in),
    .wb_valid (wb_valid),
    .wb_tag   (resp_tag),
    .wb_data  (resp_data),
    .dst_q    (dst_out),
    .mask_q   (mask_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= GS_IDLE;
      base_r   <= '0;
      idx_r    <= '0;
      addr_r   <= '0;
      issued_r <= '0;
      outst_r  <= '0;
      done_r   <= 1'b0;
      susp_r   <= 1'b0;
    end else begin
      done_r  <= 1'b0;
      outst_r <= outst_r + n_acc - n_wb;
      unique case (state)
        GS_IDLE: begin
          if (start) begin
            base_r   <= base_in;
            idx_r    <= idx_in;
            issued_r <= '0;
            susp_r   <= 1'b0;
            state    <= GS_SETUP;
          end
        end
        GS_SETUP: begin
          for (int i = 0; i < NUM_ELEM; i++) begin
            addr_r[i*ADDR_W +: ADDR_W] <= base_r + ADDR_W'(idx_r[i*IDX_W +: IDX_W]);
          end
          state <= GS_ISSUE;
        end
        GS_ISSUE: begin
          for (int p = 0; p < NUM_PORTS; p++) begin
            if (accepted[p]) issued_r[sel_tag[p*TAG_W +: TAG_W]] <= 1'b1;
          end
          if (abort) begin
            state <= GS_DRAIN;
          end else if (mask_out == '0) begin
            done_r <= 1'b1;
            state  <= GS_IDLE;
          end
        end
        GS_DRAIN: begin
          if (outst_r == '0) begin
            if (mask_out == '0) done_r <= 1'b1;
            else                susp_r <= 1'b1;
            state <= GS_IDLE;
          end
        end
        default: state <= GS_IDLE;
      endcase
    end
  end

  assign busy      = (state != GS_IDLE);
  assign done      = done_r;
  assign suspended = susp_r;
endmodule

// File: rtl/gather_seq_chk.sv
module gather_seq_chk #(
  parameter int NUM_ELEM  = 8,
  parameter int NUM_PORTS = 2,
  parameter int TAG_W     = 3,
  parameter bit SERIAL_WB = 1'b0
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       busy,
  input logic                       done,
  input logic                       suspended,
  input logic [NUM_ELEM-1:0]        mask_out,
  input logic [NUM_PORTS-1:0]       req_valid,
  input logic [NUM_PORTS*TAG_W-1:0] req_tag,
  input logic [NUM_PORTS-1:0]       resp_valid,
  input logic [NUM_PORTS-1:0]       resp_ready
);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mask_out == '0 && !busy));

  assert_suspend_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> (!busy && req_valid == '0));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (req_valid == '0));

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      assert_req_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid[p] |-> mask_out[req_tag[p*TAG_W +: TAG_W]]);
      if (p > 0) begin : g_ord
        assert_port_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
          req_valid[p] |-> (req_valid[p-1] &&
                            req_tag[(p-1)*TAG_W +: TAG_W] < req_tag[p*TAG_W +: TAG_W]));
      end
    end
    if (SERIAL_WB) begin : g_ser
      assert_single_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(resp_valid & resp_ready) <= 1);
    end
  endgenerate
endmodule

bind gather_seq gather_seq_chk #(
  .NUM_ELEM (NUM_ELEM),
  .NUM_PORTS(NUM_PORTS),
  .TAG_W    (TAG_W),
  .SERIAL_WB(SERIAL_WB)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .suspended (suspended),
  .mask_out  (mask_out),
  .req_valid (req_valid),
  .req_tag   (req_tag),
  .resp_valid(resp_valid),
  .resp_ready(resp_ready)
);

// File: tb/test_gather_seq.sv
// Memory answering each accepted request one cycle later on the same port,
// holding the answer until the block takes it.
module gather_mem_model #(
  parameter int P  = 2,
  parameter int AW = 32,
  parameter int EW = 32,
  parameter int TW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [P-1:0]    req_valid,
  output logic [P-1:0]    req_ready,
  input  logic [P*AW-1:0] req_addr,
  input  logic [P*TW-1:0] req_tag,
  output logic [P-1:0]    resp_valid,
  input  logic [P-1:0]    resp_ready,
  output logic [P*EW-1:0] resp_data,
  output logic [P*TW-1:0] resp_tag
);
  assign req_ready = ~resp_valid | resp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= '0;
      resp_data  <= '0;
      resp_tag   <= '0;
    end else begin
      for (int p = 0; p < P; p++) begin
        if (req_valid[p] && req_ready[p]) begin
          resp_valid[p]          <= 1'b1;
          resp_data[p*EW +: EW]  <= {req_addr[p*AW +: 8], req_addr[p*AW+8 +: 24]} ^ 32'h1357_9BDF;
          resp_tag[p*TW +: TW]   <= req_tag[p*TW +: TW];
        end else if (resp_ready[p]) begin
          resp_valid[p] <= 1'b0;
        end
      end
    end
  end
endmodule

module test_gather_seq;
  localparam int N  = 8;
  localparam int P  = 2;
  localparam int AW = 32;
  localparam int EW = 32;
  localparam int IW = 32;
  localparam int TW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic            start = 1'b0;
  logic            abort = 1'b0;
  logic [AW-1:0]   base_in = '0;
  logic [N*IW-1:0] idx_in = '0;
  logic [N-1:0]    mask_in = '0;
  logic [N*EW-1:0] dst_in = '0;

  logic [P-1:0]    req_valid  [2];
  logic [P-1:0]    req_ready  [2];
  logic [P*AW-1:0] req_addr   [2];
  logic [P*TW-1:0] req_tag    [2];
  logic [P-1:0]    resp_valid [2];
  logic [P-1:0]    resp_ready [2];
  logic [P*EW-1:0] resp_data  [2];
  logic [P*TW-1:0] resp_tag   [2];
  logic [N*EW-1:0] dst_out    [2];
  logic [N-1:0]    mask_out   [2];
  logic            busy       [2];
  logic            done       [2];
  logic            suspended  [2];

  // Instance 0: parallel writeback, instance 1: serialized writeback
  generate
    for (genvar g = 0; g < 2; g++) begin : g_dut
      gather_seq #(
        .NUM_ELEM(N), .ELEM_W(EW), .ADDR_W(AW), .IDX_W(IW),
        .NUM_PORTS(P), .LANE_W(128), .SERIAL_WB(g == 1)
      ) i_gather_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .base_in(base_in), .idx_in(idx_in), .mask_in(mask_in), .dst_in(dst_in),
        .req_valid(req_valid[g]), .req_ready(req_ready[g]),
        .req_addr(req_addr[g]), .req_tag(req_tag[g]),
        .resp_valid(resp_valid[g]), .resp_ready(resp_ready[g]),
        .resp_data(resp_data[g]), .resp_tag(resp_tag[g]),
        .dst_out(dst_out[g]), .mask_out(mask_out[g]),
        .busy(busy[g]), .done(done[g]), .suspended(suspended[g])
      );
      gather_mem_model #(.P(P), .AW(AW), .EW(EW), .TW(TW)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid[g]), .req_ready(req_ready[g]),
        .req_addr(req_addr[g]), .req_tag(req_tag[g]),
        .resp_valid(resp_valid[g]), .resp_ready(resp_ready[g]),
        .resp_data(resp_data[g]), .resp_tag(resp_tag[g])
      );
    end
  endgenerate

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // Expected-state tracking
  logic [AW-1:0] exp_base;
  logic [IW-1:0] exp_idx [N];
  logic [N-1:0]  op_mask;
  logic [N-1:0]  issued   [2];
  int            last_tag [2];
  int            addr_err [2];
  int            mask_err [2];
  int            ord_err  [2];
  int            done_cnt [2];
  int            ser_err;

  function automatic logic [EW-1:0] mem_fn(input logic [AW-1:0] a);
    return {a[7:0], a[31:8]} ^ 32'h1357_9BDF;
  endfunction

  function automatic logic [IW-1:0] idx_of(input int seed, input int i);
    return IW'(seed * 40503 + i * 977) ^ IW'(i << 20) ^ IW'(seed << 24);
  endfunction

  function automatic logic [N*EW-1:0] old_dst(input int seed);
    logic [N*EW-1:0] v;
    for (int i = 0; i < N; i++) v[i*EW +: EW] = 32'hD00D_0000 + EW'(seed * 16 + i);
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [N*EW-1:0] act,
                     input logic [N*EW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Log accepted requests on the falling edge before the accepting edge
  always @(negedge clk) begin
    if (rst_n) begin
      for (int m = 0; m < 2; m++) begin
        for (int p = 0; p < P; p++) begin
          if (req_valid[m][p] && req_ready[m][p]) begin
            logic [TW-1:0] t;
            t = req_tag[m][p*TW +: TW];
            if (req_addr[m][p*AW +: AW] !== exp_base + exp_idx[t]) addr_err[m]++;
            if (!op_mask[t] || issued[m][t]) mask_err[m]++;
            if (int'(t) <= last_tag[m]) ord_err[m]++;
            issued[m][t] = 1'b1;
            last_tag[m]  = int'(t);
          end
        end
        if (done[m]) done_cnt[m]++;
      end
      if ($countones(resp_valid[1] & resp_ready[1]) > 1) ser_err++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic run_op(input logic [N-1:0] m, input logic [AW-1:0] b, input int seed,
                        input logic [N*EW-1:0] dold);
    int n;
    int lat [2];
    int pc;
    logic [N*EW-1:0] exp_dst;
    @(posedge clk); #2;
    exp_base = b;
    op_mask  = m;
    for (int i = 0; i < N; i++) begin
      exp_idx[i]          = idx_of(seed, i);
      idx_in[i*IW +: IW]  = idx_of(seed, i);
      exp_dst[i*EW +: EW] = m[i] ? mem_fn(b + exp_idx[i]) : dold[i*EW +: EW];
    end
    for (int k = 0; k < 2; k++) begin
      issued[k] = '0; last_tag[k] = -1; addr_err[k] = 0;
      mask_err[k] = 0; ord_err[k] = 0; done_cnt[k] = 0; lat[k] = -1;
    end
    ser_err = 0;
    base_in = b;
    mask_in = m;
    dst_in  = dold;
    start   = 1'b1;
    @(posedge clk); #2;            // start edge
    start   = 1'b0;
    base_in = ~b;                  // R2: later changes must be ignored
    idx_in  = ~idx_in;
    mask_in = ~m;
    n = 0;
    while ((lat[0] < 0 || lat[1] < 0) && n < 100) begin
      @(negedge clk);
      for (int k = 0; k < 2; k++) if (done[k] && lat[k] < 0) lat[k] = n;
      @(posedge clk); #2;
      n++;
    end
    @(posedge clk); #2;
    @(negedge clk);
    pc = $countones(m);
    for (int k = 0; k < 2; k++) begin
      chk(addr_err[k] == 0, "R1 R2 address", addr_err[k], 0);
      chk(dst_out[k] === exp_dst, "R3 destination", dst_out[k], exp_dst);
      chk(mask_err[k] == 0 && issued[k] == m, "R3 request set", issued[k], m);
      chk(ord_err[k] == 0, "R4 order", ord_err[k], 0);
      chk(mask_out[k] == '0 && done_cnt[k] == 1, "R9 done pulse", done_cnt[k], 1);
    end
    if (m == '1) chk(lat[0] == 7, "R5 full latency", lat[0], 7);
    if (m == '0) chk(lat[0] == 2, "R5 empty latency", lat[0], 2);
    chk(ser_err == 0, "R6 single writeback", ser_err, 0);
    chk(lat[1] >= ((pc == 0) ? 2 : pc + 3), "R6 serial latency", lat[1], pc + 3);
  endtask

  initial begin
    logic [N*EW-1:0] part;
    logic [AW-1:0]   ab;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      chk(!busy[k] && !done[k] && !suspended[k] && mask_out[k] == '0 && req_valid[k] == '0,
          "R10 reset state", {busy[k], done[k], suspended[k], mask_out[k]}, 0);
    end

    for (int mk = 0; mk < (1 << N); mk++) begin
      run_op(N'(mk), 32'h1000_0003 + AW'(mk) * 32'h0001_0101, mk, old_dst(mk));
    end

    // R7 / R8: abort after the first pair is taken, then resume
    ab = 32'h2345_6789;
    @(posedge clk); #2;
    exp_base = ab;
    op_mask  = '1;
    for (int i = 0; i < N; i++) begin
      exp_idx[i]         = idx_of(999, i);
      idx_in[i*IW +: IW] = idx_of(999, i);
    end
    for (int k = 0; k < 2; k++) begin
      issued[k] = '0; last_tag[k] = -1; addr_err[k] = 0; mask_err[k] = 0; ord_err[k] = 0;
    end
    base_in = ab; mask_in = '1; dst_in = old_dst(999); start = 1'b1;
    @(posedge clk); #2 start = 1'b0;     // edge 0
    @(posedge clk); #2;                  // edge 1
    @(posedge clk); #2 abort = 1'b1;     // edge 2 took elements 0 and 1
    @(posedge clk); #2 abort = 1'b0;
    for (int w = 0; w < 20 && !(suspended[0] && suspended[1]); w++) @(posedge clk);
    @(negedge clk);
    part = old_dst(999);
    part[0 +: EW]  = mem_fn(ab + exp_idx[0]);
    part[EW +: EW] = mem_fn(ab + exp_idx[1]);
    for (int k = 0; k < 2; k++) begin
      chk(suspended[k] && !busy[k], "R7 suspended", {suspended[k], busy[k]}, 2'b10);
      chk(mask_out[k] == 8'hFC, "R7 remaining mask", mask_out[k], 8'hFC);
      chk(issued[k] == 8'h03, "R7 no issue after abort", issued[k], 8'h03);
      chk(dst_out[k] === part, "R7 partial destination", dst_out[k], part);
    end
    run_op(8'hFC, ab, 999, part);
    chk(mask_out[0] == '0 && mask_out[1] == '0, "R8 resumed gather", {mask_out[0], mask_out[1]}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule